// File: doc/BRIEF.md
# Paired 8-bit Timer Interrupt Acknowledge Unit

This unit holds the pending interrupt flags of two 8-bit timer halves, a lower one and an upper one, which the surrounding timer can also chain into a single 16-bit counter. Every event strobe from a half sets that half's flag and fires a one-cycle interrupt pulse. Software reads the flags through a status register. It acknowledges each half on its own through a write-only acknowledge register that always reads as zero.

The acknowledge register carries one more command bit, the re-raise bit. Software can clear one half and set re-raise in the same write. The clear is applied first, and the unit then pulses the interrupt again only if some flag is still pending. This gives the interrupt controller a fresh edge for the request that was not serviced. When the halves are chained (16-bit mode), the acknowledge bits are ignored, but the re-raise command still works.

The register bus has a word address, a write strobe, two byte enables and 16-bit write data. Read data is combinational from the address.

Top module: `tmr_irq_ack`

## Requirements
- R1: After reset both pending flags are 0, the interrupt output is 0, and reads from either address return 0x0000.
- R2: An event strobe on a half sets that half's pending flag on the next clock edge. The status register at word address 1 shows the lower flag in bit 0 and the upper flag in bit 1, with all other bits 0.
- R3: A write to word address 0 with the low byte enabled and data bit 0 set clears the lower flag on the next edge. A 0 in that bit leaves the flag unchanged.
- R4: A write to word address 0 with the low byte enabled and data bit 1 set clears the upper flag on the next edge. A 0 in that bit leaves the flag unchanged.
- R5: Data bits 15..8 and 6..2 of the acknowledge register are ignored. A write with only the high byte enabled has no effect on flags or interrupt.
- R6: Reading word address 0 always returns 0x0000.
- R7: While the 16-bit mode input is 1, acknowledge bits 0 and 1 have no effect on the flags.
- R8: If an event and a clear for the same half occur in the same cycle, the flag of that half is set after the edge.
- R9: The interrupt output goes high for exactly one cycle, in the cycle after any cycle that has an event strobe.
- R10: A write to word address 0 with the low byte enabled and data bit 7 set pulses the interrupt in the next cycle if a flag is pending after that write. It does nothing if no flag is pending.
- R11: When a single write sets clear bits together with bit 7, the re-raise looks only at the flags that remain after the clear. A clear of every pending flag with no same-cycle event gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address: 0 acknowledge register, 1 status register |
| bus_be | input | DATA_W/8 | Byte enables, bit 0 for data bits 7..0 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| mode16 | input | 1 | 1 when the two halves are chained as one 16-bit timer |
| evt_lo | input | 1 | Lower-half timer event strobe |
| evt_hi | input | 1 | Upper-half timer event strobe |
| pend_o | output | 2 | Pending flags, bit 0 lower, bit 1 upper |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The properties assume that each event strobe and bus write lasts a single clock cycle and that the mode input changes only between transactions. The stimulus follows this. It drives every input on the falling edge, holds the mode steady across each acknowledge write, and releases each write and event after one cycle. Before each write the bench places the unit in a known flag state built only from event strobes. It then sweeps that flag state against every combination of data pattern, byte enable, mode and same-cycle event.

// File: rtl/tia_pkg.sv
package tia_pkg;
    localparam int unsigned NUM_HALF    = 2;
    localparam int unsigned CLR_LO_BIT  = 0;
    localparam int unsigned RERAISE_BIT = 7;

    typedef struct packed {
        logic [NUM_HALF-1:0] pend;
        logic                irq;
    } tia_state_t;
endpackage

// File: rtl/tia_wr_decode.sv
module tia_wr_decode
    import tia_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned ACK_ADDR = 0
) (
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  mode16,
    output logic [NUM_HALF-1:0]   clr,
    output logic                  reraise
);
    localparam int unsigned BYTE_N = DATA_W / 8;

    logic low_hit;
    logic unused_bits;

    // only the low byte carries command bits
    assign low_hit = bus_wr && (bus_addr == ADDR_W'(ACK_ADDR)) && bus_be[0];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_HALF; gi++) begin : g_clr
            assign clr[gi] = low_hit && !mode16 && bus_wdata[CLR_LO_BIT + gi];
        end
    endgenerate

    assign reraise = low_hit && bus_wdata[RERAISE_BIT];

    assign unused_bits = ^{bus_wdata, bus_be[BYTE_N-1:1]};
endmodule

// File: rtl/tia_flag_next.sv
module tia_flag_next (
    input  logic pend_q,
    input  logic evt,
    input  logic clr,
    output logic pend_d
);
    // an event in the same cycle overrides the clear
    always_comb begin
        pend_d = pend_q;
        if (clr) begin
            pend_d = 1'b0;
        end
        if (evt) begin
            pend_d = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_irq_ack.sv
module tmr_irq_ack
    import tia_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned ACK_ADDR  = 0,
    parameter int unsigned STAT_ADDR = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                mode16,
    input  logic                evt_lo,
    input  logic                evt_hi,
    output logic [1:0]          pend_o,
    output logic                irq_o
);
    tia_state_t          st_d, st_q;
    logic [NUM_HALF-1:0] evt;
    logic [NUM_HALF-1:0] clr;
    logic [NUM_HALF-1:0] pend_nx;
    logic                reraise;

    assign evt = {evt_hi, evt_lo};

    tia_wr_decode #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ACK_ADDR (ACK_ADDR)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .mode16    (mode16),
        .clr       (clr),
        .reraise   (reraise)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_HALF; gi++) begin : g_half
            tia_flag_next u_flag (
                .pend_q (st_q.pend[gi]),
                .evt    (evt[gi]),
                .clr    (clr[gi]),
                .pend_d (pend_nx[gi])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nx;
        // re-raise sees the flags left after this cycle's clear
        st_d.irq  = (|evt) || (reraise && (|pend_nx));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_ADDR)) begin
            bus_rdata[NUM_HALF-1:0] = st_q.pend;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/tmr_irq_ack_chk.sv
module tmr_irq_ack_chk #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned ACK_ADDR = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W/8-1:0] bus_be,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                mode16,
    input logic                evt_lo,
    input logic                evt_hi,
    input logic [1:0]          pend_o,
    input logic                irq_o
);
    logic ack_wr;
    assign ack_wr = bus_wr && (bus_addr == ADDR_W'(ACK_ADDR)) && bus_be[0];

    // R2
    evt_sets_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lo |=> pend_o[0]);

    // R3
    clr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[0] && !mode16 && !evt_lo) |=> !pend_o[0]);

    // R4
    clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[1] && !mode16 && !evt_hi) |=> !pend_o[1]);

    // R6
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ACK_ADDR)) |-> (bus_rdata == '0));

    // R7
    mode16_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && !evt_lo && !evt_hi) |=> $stable(pend_o));

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hi && ack_wr && bus_wdata[1]) |=> pend_o[1]);

    // R9
    evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_lo || evt_hi) |=> irq_o);

    // R10
    quiet_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_lo && !evt_hi && !(ack_wr && bus_wdata[7])) |=> !irq_o);
endmodule

bind tmr_irq_ack tmr_irq_ack_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ACK_ADDR (ACK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode16    (mode16),
    .evt_lo    (evt_lo),
    .evt_hi    (evt_hi),
    .pend_o    (pend_o),
    .irq_o     (irq_o)
);

// File: tb/tmr_irq_ack_tb.sv
module tmr_irq_ack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mode16 = 1'b0;
    logic        evt_lo = 1'b0;
    logic        evt_hi = 1'b0;
    logic [1:0]  pend_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tmr_irq_ack u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode16(mode16), .evt_lo(evt_lo), .evt_hi(evt_hi),
        .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
        evt_lo = 1'b0; evt_hi = 1'b0; mode16 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pend", pend_o, 0);
        check("R1 irq", irq_o, 0);
        bus_addr = 2'd1; #1;
        check("R1 status read", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ip = 0; ip < 4; ip++)
        for (int pat = 0; pat < 16; pat++)
        for (int be = 0; be < 4; be++)
        for (int m = 0; m < 2; m++)
        for (int ev = 0; ev < 4; ev++) begin
            logic [15:0] w;
            logic [1:0]  clr, exp_p;
            logic        rr, exp_irq;
            string       ptag, itag;
            // clear both flags in 8-bit mode
            idle();
            bus_wr = 1'b1; bus_addr = 2'd0; bus_be = 2'b11; bus_wdata = 16'h0003;
            @(negedge clk);
            idle();
            evt_lo = ip[0]; evt_hi = ip[1];
            @(negedge clk);
            idle();
            @(negedge clk);
            // R2 status readback of built state
            bus_addr = 2'd1; #1;
            check("R2 status", bus_rdata, ip);
            check("R2 pend", pend_o, ip);

            w = 16'h0;
            if (pat[0]) w = w | 16'h0001;
            if (pat[1]) w = w | 16'h0002;
            if (pat[2]) w = w | 16'h0080;
            if (pat[3]) w = w | 16'hFF7C;
            clr   = (be[0] && m == 0) ? w[1:0] : 2'b00;
            exp_p = ev[1:0] | (ip[1:0] & ~clr);
            rr    = be[0] && w[7];
            exp_irq = (ev != 0) || (rr && exp_p != 0);

            if (m == 1)                       ptag = "R7";
            else if ((ev[1:0] & clr) != 0)    ptag = "R8";
            else if (be == 2)                 ptag = "R5";
            else if (pat[3])                  ptag = "R5 reserved";
            else                              ptag = "R3/R4";
            if (ev != 0)                      itag = "R9";
            else if (rr && clr != 0)          itag = "R11";
            else if (rr)                      itag = "R10";
            else                              itag = "R5 no-irq";

            mode16 = m[0]; bus_wr = 1'b1; bus_addr = 2'd0;
            bus_be = be[1:0]; bus_wdata = w;
            evt_lo = ev[0]; evt_hi = ev[1];
            #1;
            check("R6 ack read", bus_rdata, 0);
            @(negedge clk);
            idle();
            check(ptag, pend_o, exp_p);
            check(itag, irq_o, exp_irq);
            @(negedge clk);
            // R9 pulse lasts one cycle
            check("R9 pulse width", irq_o, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule